// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms physical byte addresses the way a 16-bit segmented processor does in real mode. It keeps four 16-bit segment registers: code, data, stack and extra. A request names one of them and gives a 16-bit offset. The block shifts the segment value left by four bits and adds the offset. The result is the physical address.

The 20-bit wrap mode is chosen per request:

- In legacy mode, anything past 1 MiB folds back to address zero.
- In extended mode, the carry is kept, so the window just above 1 MiB can be reached on a 24-bit bus.

Each request also states its access size as a power of two. The block flags a fault when the generated address is not aligned to that size.

A block-store request overrides the selector and size with fixed values:

- The segment is always the extra segment.
- The size is always 64 bytes.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream through a single output register, one cycle after acceptance. Back-pressure works as follows:

- `req_ready` is high when the output register is empty or is being drained in the same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken.

Segment loading is a plain write port that needs no handshake.

Top module: `seg_addr_gen`

## Requirements
- R1: Four 16-bit segment registers are selected by a 2-bit code: 0 code, 1 data, 2 stack, 3 extra. A write with `wr_en` high loads `wr_data` into the selected register at the clock edge.
- R2: After reset, the code segment holds 0xFFFF and the other three hold 0. `rsp_valid` is low.
- R3: The generated address equals segment × 16 + offset.
- R4: With `req_ext` = 0 (legacy), the address is the sum modulo 2^20. `rsp_addr[23:20]` is zero.
- R5: With `req_ext` = 1 (extended), the full sum is kept without wrap. It reaches at most 0x10FFEF.
- R6: `req_size` holds log2 of the access size in bytes, with codes 0 to 6 meaning 1 to 64 bytes. `rsp_fault` is 1 when any of the low `req_size` address bits is 1.
- R7: A `req_size` code of 7 always sets `rsp_fault`.
- R8: With `req_blk` = 1, the extra segment (code 3) and size code 6 (64 bytes) are used, whatever `req_sel` and `req_size` carry.
- R9: A request accepted in the same cycle as a segment write uses the segment value from before that write.
- R10: A request accepted at clock edge k appears on `rsp_*` with `rsp_valid` high right after edge k. `rsp_valid` drops after an edge where `rsp_ready` is high and nothing new is accepted.
- R11: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` and `rsp_fault` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment register to write |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_sel | input | 2 | Segment selector |
| req_off | input | 16 | Offset within the segment |
| req_size | input | 3 | log2 of the access size in bytes |
| req_ext | input | 1 | 1 = keep 24-bit carry, 0 = wrap at 1 MiB |
| req_blk | input | 1 | 64-byte block store through the extra segment |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 24 | Physical byte address |
| rsp_fault | output | 1 | Misalignment or bad size code |

## Verification
Each result is due on the outputs one clock edge after its request is accepted. A segment write is visible to requests accepted from the next edge on. The bench's reference model advances on the same edge as the design, using the inputs the bench drove at the preceding falling edge. The bench compares `rsp_*` and `req_ready` against that model 1 ns after every falling edge, so each value is read between edges, after the driven inputs have settled. Random back-pressure on `rsp_ready` covers the hold and drain cycles of the output register.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = 24;
  localparam int LEGACY_W  = 20;
  localparam int NUM_SEG   = 4;
  localparam int SEL_W     = $clog2(NUM_SEG);
  localparam int SZ_W      = 3;
  localparam int MAX_SZ    = 6;
  localparam logic [SEL_W-1:0] SEL_EXTRA = 2'd3;
  localparam logic [SEG_W-1:0] CODE_RST  = 16'hFFFF;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int NS = NUM_SEG,
  parameter logic [SW-1:0] CODE_RESET = CODE_RST,
  localparam int LW = $clog2(NS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LW-1:0]         wr_sel,
  input  logic [SW-1:0]         wr_data,
  output logic [NS-1:0][SW-1:0] seg_q
);
  for (genvar gi = 0; gi < NS; gi++) begin : g_seg
    localparam logic [SW-1:0] RST_VAL = (gi == 0) ? CODE_RESET : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[gi] <= RST_VAL;
      else if (wr_en && (wr_sel == LW'(gi)))
        seg_q[gi] <= wr_data;
    end
  end

  // R1
  seg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_addr_pkg::*;
#(
  parameter int SW  = SEG_W,
  parameter int OW  = OFF_W,
  parameter int SH  = SEG_SHIFT,
  parameter int AW  = PA_W,
  parameter int LGW = LEGACY_W,
  parameter int ZW  = SZ_W,
  parameter int MZ  = MAX_SZ,
  localparam int SUM_W = SW + SH + 1
) (
  input  logic [SW-1:0] seg_val,
  input  logic [OW-1:0] off,
  input  logic [ZW-1:0] size_code,
  input  logic          ext_mode,
  output logic [AW-1:0] addr,
  output logic          fault
);
  logic [SUM_W-1:0] sum;
  logic [MZ-1:0]    low_mask;
  logic             size_bad;

  always_comb begin
    sum = {1'b0, seg_val, {SH{1'b0}}} + SUM_W'(off);
    if (ext_mode)
      addr = {{(AW-SUM_W){1'b0}}, sum};
    else
      addr = {{(AW-LGW){1'b0}}, sum[LGW-1:0]};
  end

  for (genvar gb = 0; gb < MZ; gb++) begin : g_mask
    assign low_mask[gb] = (int'(size_code) > gb);
  end

  assign size_bad = int'(size_code) > MZ;
  assign fault    = size_bad || (|(addr[MZ-1:0] & low_mask));
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_addr_pkg::*;
#(
  parameter int AW  = PA_W,
  parameter int LGW = LEGACY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_fault,
  input  logic          in_ext,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_fault
);
  logic ext_q;
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fault <= 1'b0;
      ext_q     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_fault <= in_fault;
      ext_q     <= in_ext;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_fault));

  // R10
  accept_shows_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R4
  legacy_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !ext_q |-> out_addr[AW-1:LGW] == '0);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_ext,
  input  logic              req_blk,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_addr,
  output logic              rsp_fault
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEL_W-1:0] eff_sel;
  logic [SZ_W-1:0]  eff_size;
  logic [PA_W-1:0]  calc_addr;
  logic             calc_fault;
  logic             blk_q;

  seg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seg_q(seg_q)
  );

  assign eff_sel  = req_blk ? SEL_EXTRA : req_sel;
  assign eff_size = req_blk ? SZ_W'(MAX_SZ) : req_size;

  seg_addr_calc u_calc (
    .seg_val(seg_q[eff_sel]), .off(req_off), .size_code(eff_size),
    .ext_mode(req_ext), .addr(calc_addr), .fault(calc_fault)
  );

  seg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(calc_addr), .in_fault(calc_fault), .in_ext(req_ext),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_addr(rsp_addr),
    .out_fault(rsp_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      blk_q <= 1'b0;
    else if (req_valid && req_ready)
      blk_q <= req_blk;
  end

  // R8
  blk_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && blk_q && !rsp_fault |-> rsp_addr[MAX_SZ-1:0] == '0);
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_sel = '0;
  logic [15:0] req_off = '0;
  logic [2:0] req_size = '0;
  logic req_ext = 1'b0;
  logic req_blk = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [23:0] rsp_addr;
  logic rsp_fault;

  always #2.5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_off(req_off), .req_size(req_size), .req_ext(req_ext), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R2";
  bit rand_ready = 1'b0;
  bit finished = 1'b0;

  // reference model state
  int m_seg [4];
  bit m_valid;
  int m_addr;
  bit m_fault;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_seg = '{32'hFFFF, 0, 0, 0};
      m_valid = 1'b0;
      m_addr = 0;
      m_fault = 1'b0;
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        int s, sz, a;
        s  = req_blk ? 3 : int'(req_sel);
        sz = req_blk ? 6 : int'(req_size);
        a  = m_seg[s] * 16 + int'(req_off);
        if (!req_ext) a = a % (1 << 20);
        m_valid = 1'b1;
        m_addr  = a;
        m_fault = (sz > 6) || ((a % (1 << sz)) != 0);
      end else if (rsp_ready) begin
        m_valid = 1'b0;
      end
      if (wr_en) m_seg[wr_sel] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    #1;
    if (!finished) begin
      chk(rsp_valid == m_valid, "rsp_valid", int'(rsp_valid), int'(m_valid));
      chk(req_ready == (!m_valid || rsp_ready), "req_ready (R11)", int'(req_ready),
          int'(!m_valid || rsp_ready));
      if (m_valid) begin
        chk(int'(rsp_addr) == m_addr, "rsp_addr", int'(rsp_addr), m_addr);
        chk(rsp_fault == m_fault, "rsp_fault", int'(rsp_fault), int'(m_fault));
      end
    end
  end

  always @(negedge clk) if (rand_ready) rsp_ready = ($urandom % 3) != 0;

  task automatic send(input int sel, input int off, input int sz, input bit ext,
                      input bit blk, input bit we = 0, input int wsel = 0, input int wdat = 0);
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'(sel); req_off = 16'(off); req_size = 3'(sz);
    req_ext = ext; req_blk = blk;
    wr_en = we; wr_sel = 2'(wsel); wr_data = 16'(wdat);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input int sel, input int dat);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(dat);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tag = "R2"; send(0, 0, 0, 1, 0);
    send(1, 0, 0, 0, 0);
    tag = "R1"; wr(1, 16'h1234); wr(2, 16'hABCD);
    tag = "R3"; send(1, 5, 0, 0, 0); send(2, 16'h0100, 0, 1, 0);
    tag = "R4"; send(0, 16'h0010, 0, 0, 0); send(0, 16'hFFFF, 0, 0, 0);
    tag = "R5"; send(0, 16'h0010, 0, 1, 0); send(0, 16'hFFFF, 0, 1, 0);
    tag = "R6"; wr(3, 0);
    for (int z = 0; z < 7; z++) begin
      send(3, 1 << z, z, 0, 0);
      send(3, (1 << z) + 2, z, 0, 0);
    end
    tag = "R7"; send(3, 0, 7, 0, 0); send(3, 16'h0040, 7, 1, 0);
    tag = "R8"; wr(3, 16'h2000);
    send(1, 16'h0040, 0, 0, 1); send(0, 16'h0041, 0, 0, 1); send(2, 16'h0020, 7, 1, 1);
    tag = "R9"; send(1, 16'h0007, 0, 0, 0, 1, 1, 16'h5555); send(1, 16'h0007, 0, 0, 0);
    tag = "R10"; repeat (3) @(negedge clk);
    tag = "R11"; rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) wr($urandom % 4, $urandom % 65536);
      send($urandom % 4, $urandom % 65536, $urandom % 8, 1'($urandom), ($urandom % 6) == 0);
      if ($urandom % 4 == 0) @(negedge clk);
    end
    rand_ready = 1'b0; rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule